// File: doc/BRIEF.md
# Shared-Bus 8-bit CPU Datapath

This block is the register and memory datapath of a small 8-bit processor. All of its units trade data over one shared 8-bit bus. The units are an accumulator, an operand register, an instruction register, an adder, a 4-bit program counter, a 4-bit memory address register and a 16-byte RAM. Each unit has its own pair of strobes: one puts its value on the bus, and the other captures the bus on the rising clock edge. An external debug source can also drive the bus while its enable is high.

The block does no sequencing of its own. It carries out exactly the strobes it receives on each cycle, and an outside controller or a test harness supplies them. Inside the design, the bus is a multiplexer gated by the output enables. It is exposed as a data port together with a flag that tells whether anything drives it. When no source is enabled the bus floats: the flag is low and the data port reads zero.

Top module: `cpu_bus_top`

## Requirements
- R1: After reset (rstN low, active low), the accumulator, operand register, instruction register, program counter, address register and every RAM byte hold zero. With no output strobe active, busDriven is 0 and busData is 0.
- R2: The sources are aOut, bOut, insOut, aluOut, ramOut, pcOut and dbgEn. busDriven is 1 when exactly one of them is high, and 0 with busData 0 when none is. Two or more at once is illegal, and an assertion flags it.
- R3: aLoad and bLoad capture busData into the accumulator and the operand register at the rising edge. aOut and bOut put those values on the bus in the same cycle.
- R4: insLoad captures all 8 bus bits. insOut drives bits 3:0 of the instruction register onto the bus, with bits 7:4 zero (0xCC reads back as 0x0C).
- R5: aluOut drives (accumulator + operand register) mod 256 (0xAA + 0xBB reads 0x65).
- R6: pcLoad captures busData[3:0] into the program counter. pcOut drives {4'b0000, pc}.
- R7: pcCount adds one to the program counter at the edge, wrapping from 15 to 0. When pcLoad and pcCount are both high, the load wins.
- R8: marLoad captures busData[3:0] as the RAM address. ramWrite stores busData at that address. ramOut drives the byte stored at the current address.
- R9: While dbgEn is high, busData equals dbgData. When dbgEn falls, the debug source releases the bus.
- R10: A register whose load strobe is low keeps its value, whatever the bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all loads on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aOut | input | 1 | Accumulator drives bus |
| bOut | input | 1 | Operand register drives bus |
| insOut | input | 1 | Instruction register low nibble drives bus |
| aluOut | input | 1 | Adder sum drives bus |
| ramOut | input | 1 | Addressed RAM byte drives bus |
| pcOut | input | 1 | Program counter drives bus |
| pcCount | input | 1 | Program counter increment |
| aLoad | input | 1 | Accumulator loads from bus |
| bLoad | input | 1 | Operand register loads from bus |
| insLoad | input | 1 | Instruction register loads from bus |
| ramWrite | input | 1 | RAM writes bus at addressed byte |
| pcLoad | input | 1 | Program counter loads bus low nibble |
| marLoad | input | 1 | Address register loads bus low nibble |
| dbgEn | input | 1 | Debug source drives bus |
| dbgData | input | 8 | Debug source value |
| busData | output | 8 | Current bus value (0 when floating) |
| busDriven | output | 1 | High when one source drives the bus |

## Verification
On every cycle, the assertions check three things: no more than one source drives the bus, the bus floats when nothing is enabled, and the instruction register's upper nibble never reaches the bus. They also check the program counter on each cycle: it follows a load, and otherwise it steps by one with wrap-around. The bench's scenarios cover what the assertions do not. They sweep the adder over many operand pairs and every instruction-register value, write and read back all RAM addresses, and show that a register keeps its value when the bus changes while its load strobe is low.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
  localparam int NSRC = 7;
  localparam int SRC_A   = 0;
  localparam int SRC_B   = 1;
  localparam int SRC_INS = 2;
  localparam int SRC_ALU = 3;
  localparam int SRC_RAM = 4;
  localparam int SRC_PC  = 5;
  localparam int SRC_DBG = 6;

  typedef struct packed {
    logic aLoad;
    logic bLoad;
    logic insLoad;
    logic ramWrite;
    logic pcLoad;
    logic pcCount;
    logic marLoad;
  } loadStrobes_t;
endpackage

// File: rtl/cpu_bus_ctrl.sv
module cpu_bus_ctrl
  import cpu_bus_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic aOut,
  input  logic bOut,
  input  logic insOut,
  input  logic aluOut,
  input  logic ramOut,
  input  logic pcOut,
  input  logic pcCount,
  input  logic aLoad,
  input  logic bLoad,
  input  logic insLoad,
  input  logic ramWrite,
  input  logic pcLoad,
  input  logic marLoad,
  input  logic dbgEn,
  output loadStrobes_t ld,
  output logic [NSRC-1:0] srcSel
);
  always_comb begin
    srcSel          = '0;
    srcSel[SRC_A]   = aOut;
    srcSel[SRC_B]   = bOut;
    srcSel[SRC_INS] = insOut;
    srcSel[SRC_ALU] = aluOut;
    srcSel[SRC_RAM] = ramOut;
    srcSel[SRC_PC]  = pcOut;
    srcSel[SRC_DBG] = dbgEn;
  end

  always_comb begin
    ld.aLoad    = aLoad;
    ld.bLoad    = bLoad;
    ld.insLoad  = insLoad;
    ld.ramWrite = ramWrite;
    ld.pcLoad   = pcLoad;
    ld.pcCount  = pcCount;
    ld.marLoad  = marLoad;
  end

  // R2: two sources on the bus at once is illegal
  p_one_driver_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aOut, bOut, insOut, aluOut, ramOut, pcOut, dbgEn}))
    else $error("bus contention");
endmodule

// File: rtl/cpu_bus_datapath.sv
module cpu_bus_datapath
  import cpu_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  loadStrobes_t ld,
  input  logic [NSRC-1:0] srcSel,
  input  logic [DATA_W-1:0] dbgData,
  output logic [DATA_W-1:0] busData,
  output logic busDriven
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NIB   = DATA_W / 2;

  logic [DATA_W-1:0] regA, regB, insReg;
  logic [ADDR_W-1:0] pcVal, marVal;
  logic [DATA_W-1:0] ramArr [DEPTH];
  logic [DATA_W-1:0] srcVal [NSRC];

  always_comb begin
    srcVal[SRC_A]   = regA;
    srcVal[SRC_B]   = regB;
    srcVal[SRC_INS] = {{(DATA_W-NIB){1'b0}}, insReg[NIB-1:0]};
    srcVal[SRC_ALU] = regA + regB;
    srcVal[SRC_RAM] = ramArr[marVal];
    srcVal[SRC_PC]  = {{(DATA_W-ADDR_W){1'b0}}, pcVal};
    srcVal[SRC_DBG] = dbgData;
  end

  // bus: OR of enabled sources (legal use has at most one)
  always_comb begin
    busData = '0;
    for (int i = 0; i < NSRC; i++)
      if (srcSel[i]) busData = busData | srcVal[i];
  end
  assign busDriven = |srcSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA   <= '0;
      regB   <= '0;
      insReg <= '0;
      pcVal  <= '0;
      marVal <= '0;
    end else begin
      if (ld.aLoad)   regA   <= busData;
      if (ld.bLoad)   regB   <= busData;
      if (ld.insLoad) insReg <= busData;
      if (ld.marLoad) marVal <= busData[ADDR_W-1:0];
      if (ld.pcLoad)       pcVal <= busData[ADDR_W-1:0];
      else if (ld.pcCount) pcVal <= pcVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ramArr[i] <= '0;
    end else if (ld.ramWrite) begin
      ramArr[marVal] <= busData;
    end
  end

  // R2: floating bus reads zero and is flagged undriven
  p_float_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == '0) |-> (!busDriven && busData == '0));
  // R4: upper nibble of instruction register never reaches the bus
  p_ins_nibble_r4: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == (NSRC'(1) << SRC_INS)) |-> (busData[DATA_W-1:NIB] == '0));
  // R7: load wins over count
  p_pc_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    ld.pcLoad |=> (pcVal == $past(busData[ADDR_W-1:0])));
  // R7: increment with wrap
  p_pc_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ld.pcCount && !ld.pcLoad) |=> (pcVal == $past(pcVal) + 1'b1));
  // R10: no load strobe, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ld.aLoad |=> $stable(regA));
endmodule

// File: rtl/cpu_bus_top.sv
module cpu_bus_top
  import cpu_bus_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic aOut,
  input  logic bOut,
  input  logic insOut,
  input  logic aluOut,
  input  logic ramOut,
  input  logic pcOut,
  input  logic pcCount,
  input  logic aLoad,
  input  logic bLoad,
  input  logic insLoad,
  input  logic ramWrite,
  input  logic pcLoad,
  input  logic marLoad,
  input  logic dbgEn,
  input  logic [7:0] dbgData,
  output logic [7:0] busData,
  output logic busDriven
);
  loadStrobes_t ld;
  logic [NSRC-1:0] srcSel;

  cpu_bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .aOut(aOut), .bOut(bOut), .insOut(insOut), .aluOut(aluOut),
    .ramOut(ramOut), .pcOut(pcOut), .pcCount(pcCount),
    .aLoad(aLoad), .bLoad(bLoad), .insLoad(insLoad), .ramWrite(ramWrite),
    .pcLoad(pcLoad), .marLoad(marLoad), .dbgEn(dbgEn),
    .ld(ld), .srcSel(srcSel)
  );

  cpu_bus_datapath #(.DATA_W(8), .ADDR_W(4)) u_dp (
    .clk(clk), .rstN(rstN), .ld(ld), .srcSel(srcSel),
    .dbgData(dbgData), .busData(busData), .busDriven(busDriven)
  );
endmodule

// File: tb/sim_cpu_bus_top.sv
`timescale 1ns/100ps
module sim_cpu_bus_top;
  logic clk = 0;
  logic rstN = 0;
  logic aOut, bOut, insOut, aluOut, ramOut, pcOut, pcCount;
  logic aLoad, bLoad, insLoad, ramWrite, pcLoad, marLoad, dbgEn;
  logic [7:0] dbgData;
  logic [7:0] busData;
  logic busDriven;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  cpu_bus_top u0 (.*);

  task automatic clearS();
    {aOut, bOut, insOut, aluOut, ramOut, pcOut, pcCount} = '0;
    {aLoad, bLoad, insLoad, ramWrite, pcLoad, marLoad, dbgEn} = '0;
    dbgData = 8'h00;
  endtask

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%03h expected 0x%03h", tag, got, exp);
    end
  endtask

  // sample bus (with driven flag) mid-low phase, then finish the cycle
  task automatic peek(input string tag, input logic [8:0] exp);
    #1;
    check(tag, {busDriven, busData}, exp);
    @(negedge clk);
    clearS();
  endtask

  task automatic dbgPut(input logic [7:0] v);
    dbgEn = 1; dbgData = v;
  endtask

  task automatic cyc();
    @(negedge clk);
    clearS();
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk + 1);
    $finish;
  end

  initial begin
    clearS();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    peek("R1 idle bus", 9'h000);
    aOut = 1;   peek("R1 A reset", 9'h100);
    bOut = 1;   peek("R1 B reset", 9'h100);
    insOut = 1; peek("R1 IR reset", 9'h100);
    pcOut = 1;  peek("R1 PC reset", 9'h100);
    ramOut = 1; peek("R1 RAM reset", 9'h100);

    // R9 debug drive and release, R2 float
    dbgPut(8'h5A); peek("R9 debug drives", 9'h15A);
    peek("R2 released floats", 9'h000);

    // R4 every instruction-register value
    for (int v = 0; v < 256; v++) begin
      dbgPut(v[7:0]); insLoad = 1; cyc();
      insOut = 1; peek("R4 ins low nibble", {1'b1, 4'h0, v[3:0]});
    end

    // R5 / R3 adder sweep
    for (int b = 0; b < 256; b += 17) begin
      dbgPut(b[7:0]); bLoad = 1; cyc();
      bOut = 1; peek("R3 B readback", {1'b1, b[7:0]});
      for (int a = 0; a < 256; a++) begin
        dbgPut(a[7:0]); aLoad = 1; cyc();
        aluOut = 1; peek("R5 alu sum", {1'b1, 8'(a + b)});
      end
    end
    dbgPut(8'hAA); aLoad = 1; cyc();
    dbgPut(8'hBB); bLoad = 1; cyc();
    aluOut = 1; peek("R5 AA+BB", 9'h165);
    aOut = 1; peek("R3 A readback", 9'h1AA);
    aluOut = 1; aLoad = 1; cyc();   // A <= A+B via bus
    aOut = 1; peek("R3 A loads alu", 9'h165);

    // R10 hold: bus busy, no load strobes
    dbgPut(8'hFF); cyc();
    dbgPut(8'h00); cyc();
    aOut = 1; peek("R10 A held", 9'h165);
    bOut = 1; peek("R10 B held", 9'h1BB);
    insOut = 1; peek("R10 IR held", 9'h10F);

    // R6 / R7 program counter
    dbgPut(8'hF7); pcLoad = 1; cyc();
    pcOut = 1; peek("R6 pc low nibble", 9'h107);
    dbgPut(8'h0D); pcLoad = 1; cyc();
    for (int k = 1; k <= 5; k++) begin
      pcCount = 1; cyc();
      pcOut = 1; peek("R7 pc count wrap", {1'b1, 4'h0, 4'((13 + k) % 16)});
    end
    dbgPut(8'h09); pcLoad = 1; pcCount = 1; cyc();
    pcOut = 1; peek("R7 load beats count", 9'h109);
    cyc();
    pcOut = 1; peek("R10 pc held", 9'h109);

    // R8 RAM all addresses, upper bus bits ignored for address
    for (int ad = 0; ad < 16; ad++) begin
      dbgPut({4'hA, ad[3:0]}); marLoad = 1; cyc();
      dbgPut(8'(ad * 37 + 11)); ramWrite = 1; cyc();
    end
    for (int ad = 15; ad >= 0; ad--) begin
      dbgPut({4'h5, ad[3:0]}); marLoad = 1; cyc();
      ramOut = 1; peek("R8 ram readback", {1'b1, 8'(ad * 37 + 11)});
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule